// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, 96 by default. The lines are grouped into banks of 32, and the block raises a single interrupt request towards the processor. Software uses a 32-bit register bus with an address, a write strobe, write data and combinational read data. Through this bus it can:
- enable and disable lines through write-one aliases of each bank's mask;
- read each bank's pending lines after masking;
- read the number of the interrupt currently presented;
- acknowledge that interrupt so that the next one can be selected.

A selection state machine has three states:
- `SEL_IDLE`: nothing is presented. If any pending bit is set, the machine takes the transition *latch*: it records the lowest-numbered pending line and moves to `SEL_HOLD`.
- `SEL_HOLD`: the request output is high and the recorded number is frozen. An acknowledge write takes the transition *release* to `SEL_GAP`.
- `SEL_GAP`: the request output is low for exactly one cycle. The machine then either *relatches* the lowest pending line and returns to `SEL_HOLD`, or goes *quiet* back to `SEL_IDLE`.

A second state machine handles the soft reset, which software starts through the configuration register:
- `SR_IDLE` takes the transition *start* when the reset bit is written.
- `SR_RUN` holds every register at its reset value for a fixed number of cycles and blocks bus writes during that time.
- `SR_RUN` takes the transition *finish* back to `SR_IDLE`. The configuration bit then clears itself and the status bit reports completion.

The block also holds a revision byte, plain storage for threshold, idle and protection settings, and one small storage register per line.

Top module: `lvl_irq_hub`

## Requirements
- R1: After hardware reset:
  - every mask bit reads 1;
  - `cpu_irq` is low and the active number at 0x040 reads 0;
  - the status register at 0x014 reads 1;
  - the configuration register at 0x010 reads 0;
  - threshold, idle and protection read 0.
- R2: Each bank b has a mask register at 0x084+0x20*b. A 1 in a mask bit means the line is disabled.
  - Writing 1s to 0x08C+0x20*b sets the matching mask bits.
  - Writing 1s to 0x088+0x20*b clears them.
  - Zero bits in either alias leave the mask unchanged.
  - A write to 0x084+0x20*b replaces the whole mask.
- R3: Each bank's pending register at 0x098+0x20*b reads the raw line levels ANDed with the inverted mask.
- R4: In `SEL_IDLE`, if any line is pending, the lowest-numbered pending line is recorded and `cpu_irq` is high from the next cycle. The number reads in bits 6:0 of 0x040, and the upper bits read 0.
- R5: While `cpu_irq` is high, the recorded number does not change. This holds even when a lower-numbered line becomes pending and even when the recorded line's level drops.
- R6: Writing 1 to bit 0 of 0x048 while `cpu_irq` is high drops `cpu_irq` for exactly one cycle. In that cycle the next pending line is selected. A write with bit 0 clear has no effect.
- R7: Writing 1 to bit 1 of 0x010 starts a soft reset.
  - For RST_CYC cycles, bit 1 of 0x010 reads 1 and bit 0 of 0x014 reads 0.
  - After that, all registers hold their R1 values, bit 1 has cleared itself, and 0x014 reads 1.
- R8: Bit 0 of 0x010 is an autoidle setting that reads back as written.
- R9: The low byte of 0x000 reads the revision, with the major number in bits 7:4 and the minor number in bits 3:0. The defaults are 2 and 1, so the byte reads 0x21.
- R10: The block keeps three plain storage fields, and unused bits read 0:
  - protection in bit 0 of 0x04C;
  - idle in bits 1:0 of 0x050;
  - threshold in bits 7:0 of 0x068.
- R11: Line n has a storage register of LVL_W bits (8 by default) at 0x100+4*n. It reads back as written, its upper bits read 0, and it clears on reset.
- R12: NUM_LINES is a multiple of 32 and no more than 128. Addresses that map no register read 0, including bank offsets beyond the last bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | NUM_LINES | Raw interrupt levels, synchronous to `clk` |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is a held selection being disturbed. A higher-numbered line is presented, then a lower-numbered line becomes pending, then the presented line's level drops, and after that the acknowledge must produce exactly one low cycle before the lower line is relatched. The stimulus first presents line 32 alone. It then unmasks and raises line 2 and drops line 32, checking the held number after each change. Finally it samples `cpu_irq` in the cycle right after the acknowledge write and again one cycle later. A table of mask and level patterns then covers priority across bank boundaries and masked lower lines.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int unsigned ADDR_W         = 12;
    localparam int unsigned DATA_W         = 32;
    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned THR_W          = 8;
    localparam int unsigned IDLE_W         = 2;
    localparam int unsigned PROT_W         = 1;

    localparam logic [ADDR_W-1:0] A_REV  = 12'h000;
    localparam logic [ADDR_W-1:0] A_CFG  = 12'h010;
    localparam logic [ADDR_W-1:0] A_STAT = 12'h014;
    localparam logic [ADDR_W-1:0] A_ACT  = 12'h040;
    localparam logic [ADDR_W-1:0] A_CTRL = 12'h048;
    localparam logic [ADDR_W-1:0] A_PROT = 12'h04C;
    localparam logic [ADDR_W-1:0] A_IDLE = 12'h050;
    localparam logic [ADDR_W-1:0] A_THR  = 12'h068;

    localparam logic [ADDR_W-1:0] BANK_BASE   = 12'h080;
    localparam int unsigned       BANK_STRIDE = 32;
    localparam logic [4:0]        S_MASK      = 5'h04;
    localparam logic [4:0]        S_CLR       = 5'h08;
    localparam logic [4:0]        S_SET       = 5'h0C;
    localparam logic [4:0]        S_PEND      = 5'h18;

    localparam logic [ADDR_W-1:0] LVL_BASE = 12'h100;

    typedef enum logic [1:0] {
        SEL_IDLE = 2'd0,
        SEL_HOLD = 2'd1,
        SEL_GAP  = 2'd2
    } sel_state_e;

    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_RUN  = 1'b1
    } srst_state_e;
endpackage

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [W-1:0] raw,
    input  logic         mask_wr,
    input  logic         mask_set,
    input  logic         mask_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '1;
        else if (soft_clr) mask_q <= '1;
        else if (mask_wr)  mask_q <= wdata;
        else if (mask_set) mask_q <= mask_q | wdata;
        else if (mask_clr) mask_q <= mask_q & ~wdata;
    end

    assign pend = raw & ~mask_q;

    // R2: set alias forces every written 1 into the mask
    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set && !mask_wr && !soft_clr) |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R2: clear alias removes every written 1 from the mask
    a_r2_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr && !mask_set && !mask_wr && !soft_clr) |=> ((mask_q & $past(wdata)) == '0));

    // R2: zero bits of an alias keep their old mask value
    a_r2_zero_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_set || mask_clr) && !mask_wr && !soft_clr)
            |=> ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
endmodule

// File: rtl/lvl_irq_sel.sv
module lvl_irq_sel
    import lvl_irq_pkg::*;
#(
    parameter int unsigned N    = 96,
    parameter int unsigned ID_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic [N-1:0]    pend,
    input  logic            ack,
    output logic            irq,
    output logic [ID_W-1:0] act_id
);
    sel_state_e      state_q, state_d;
    logic            any_pend;
    logic [ID_W-1:0] low_id;

    assign any_pend = |pend;

    always_comb begin
        low_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) low_id = ID_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE: state_d = any_pend ? SEL_HOLD : SEL_IDLE;
            SEL_HOLD: state_d = ack      ? SEL_GAP  : SEL_HOLD;
            SEL_GAP:  state_d = any_pend ? SEL_HOLD : SEL_IDLE;
            default:  state_d = SEL_IDLE;
        endcase
        if (soft_clr) state_d = SEL_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        act_id <= '0;
        else if (soft_clr) act_id <= '0;
        else if ((state_q == SEL_IDLE || state_q == SEL_GAP) && any_pend)
            act_id <= low_id;
    end

    assign irq = (state_q == SEL_HOLD);

    // R4: a pending line seen while idle raises the request next cycle
    a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_IDLE && any_pend && !soft_clr) |=> irq);

    // R5: the presented number is frozen until acknowledged
    a_r5_hold_id: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_HOLD && !ack && !soft_clr) |=> (irq && $stable(act_id)));

    // R6: an acknowledge always yields a low request cycle
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_HOLD && ack && !soft_clr) |=> !irq);
endmodule

// File: rtl/lvl_irq_srst.sv
module lvl_irq_srst
    import lvl_irq_pkg::*;
#(
    parameter int unsigned CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(CYC + 1);

    srst_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: state_d = start ? SR_RUN : SR_IDLE;
            SR_RUN:  state_d = (cnt_q == '0) ? SR_IDLE : SR_RUN;
            default: state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (state_q == SR_IDLE && start) cnt_q <= CNT_W'(CYC - 1);
        else if (state_q == SR_RUN)           cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (state_q == SR_RUN);

    // R7: a start request while idle begins the reset sequence
    a_r7_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_IDLE && start) |=> busy);

    // R7: the reset sequence is bounded by its cycle count
    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(cnt_q) < CYC));
endmodule

// File: rtl/lvl_irq_hub.sv
module lvl_irq_hub
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 96,
    parameter int unsigned LVL_W     = 8,
    parameter int unsigned RST_CYC   = 4,
    parameter int unsigned REV_MAJOR = 2,
    parameter int unsigned REV_MINOR = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 cpu_irq
);
    localparam int unsigned NBANK  = NUM_LINES / LINES_PER_BANK;
    localparam int unsigned ID_W   = $clog2(NUM_LINES);
    localparam int unsigned LIDX_W = $clog2(NUM_LINES);
    localparam int unsigned BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam logic [ADDR_W-1:0] BANK_END =
        ADDR_W'(32'(BANK_BASE) + BANK_STRIDE * NBANK);
    localparam logic [ADDR_W-1:0] LVL_END =
        ADDR_W'(32'(LVL_BASE) + 4 * NUM_LINES);
    localparam logic [7:0] REV_BYTE = {4'(REV_MAJOR), 4'(REV_MINOR)};

    logic                 busy, wr_ok, srst_start, ack;
    logic                 in_bank, in_lvl;
    logic [BIDX_W-1:0]    bidx;
    logic [4:0]           bsub;
    logic [LIDX_W-1:0]    lidx;
    logic [NUM_LINES-1:0] pend_all;
    logic [DATA_W-1:0]    mask_a [NBANK];
    logic [DATA_W-1:0]    pend_a [NBANK];
    logic [DATA_W-1:0]    bank_rd;
    logic [ID_W-1:0]      act_id;

    logic              autoidle_q;
    logic [PROT_W-1:0] prot_q;
    logic [IDLE_W-1:0] idle_q;
    logic [THR_W-1:0]  thr_q;
    logic [LVL_W-1:0]  lvl_q [NUM_LINES];

    assign wr_ok      = bus_wr && !busy;
    assign srst_start = wr_ok && (bus_addr == A_CFG) && bus_wdata[1];
    assign ack        = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];

    assign in_bank = (bus_addr >= BANK_BASE) && (bus_addr < BANK_END);
    assign bidx    = BIDX_W'((bus_addr - BANK_BASE) >> 5);
    assign bsub    = bus_addr[4:0];
    assign in_lvl  = (bus_addr >= LVL_BASE) && (bus_addr < LVL_END) &&
                     (bus_addr[1:0] == 2'b00);
    assign lidx    = LIDX_W'((bus_addr - LVL_BASE) >> 2);

    lvl_irq_srst #(.CYC(RST_CYC)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (busy)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = wr_ok && in_bank && (bidx == BIDX_W'(b));

        lvl_irq_bank #(.W(LINES_PER_BANK)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (busy),
            .raw      (irq_lines[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .mask_wr  (hit && (bsub == S_MASK)),
            .mask_set (hit && (bsub == S_SET)),
            .mask_clr (hit && (bsub == S_CLR)),
            .wdata    (bus_wdata),
            .mask_q   (mask_a[b]),
            .pend     (pend_a[b])
        );

        assign pend_all[b*LINES_PER_BANK +: LINES_PER_BANK] = pend_a[b];
    end

    lvl_irq_sel #(.N(NUM_LINES), .ID_W(ID_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (busy),
        .pend     (pend_all),
        .ack      (ack),
        .irq      (cpu_irq),
        .act_id   (act_id)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || busy) begin
            autoidle_q <= 1'b0;
            prot_q     <= '0;
            idle_q     <= '0;
            thr_q      <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                A_CFG:   autoidle_q <= bus_wdata[0];
                A_PROT:  prot_q     <= bus_wdata[PROT_W-1:0];
                A_IDLE:  idle_q     <= bus_wdata[IDLE_W-1:0];
                A_THR:   thr_q      <= bus_wdata[THR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || busy) begin
            for (int i = 0; i < NUM_LINES; i++) lvl_q[i] <= '0;
        end else if (wr_ok && in_lvl) begin
            lvl_q[lidx] <= bus_wdata[LVL_W-1:0];
        end
    end

    always_comb begin
        bank_rd = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bidx == BIDX_W'(b)) begin
                case (bsub)
                    S_MASK:  bank_rd = mask_a[b];
                    S_PEND:  bank_rd = pend_a[b];
                    default: bank_rd = '0;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_REV:  bus_rdata = 32'(REV_BYTE);
            A_CFG:  bus_rdata = {30'b0, busy, autoidle_q};
            A_STAT: bus_rdata = {31'b0, !busy};
            A_ACT:  bus_rdata = 32'(act_id);
            A_PROT: bus_rdata = 32'(prot_q);
            A_IDLE: bus_rdata = 32'(idle_q);
            A_THR:  bus_rdata = 32'(thr_q);
            default: begin
                if (in_bank)     bus_rdata = bank_rd;
                else if (in_lvl) bus_rdata = 32'(lvl_q[lidx]);
            end
        endcase
    end

    // R4: a presented number always names an existing line
    a_r4_id_range: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (32'(act_id) < NUM_LINES));

    // R7: no request is presented while the soft reset runs
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!cpu_irq || busy == 1'b0));

    // R12: the line count fits whole banks and the seven-bit number field
    initial begin
        a_r12_lines: assert ((NUM_LINES % LINES_PER_BANK) == 0 && NUM_LINES <= 128);
    end
endmodule

// File: tb/lvl_irq_hub_tb.sv
module lvl_irq_hub_tb;
    localparam int NL = 96;

    typedef struct packed {
        logic [NL-1:0] raw;
        logic [NL-1:0] en;
        logic [7:0]    id;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{(96'd1 << 5),                   {96{1'b1}},     8'd5},
        '{(96'd1 << 40) | (96'd1 << 70),  {96{1'b1}},     8'd40},
        '{(96'd1 << 3)  | (96'd1 << 40),  (96'd1 << 40),  8'd40},
        '{(96'd1 << 95),                  (96'd1 << 95),  8'd95},
        '{(96'd1 << 0)  | (96'd1 << 64),  (96'd1 << 64),  8'd64},
        '{(96'd1 << 31) | (96'd1 << 32),  {96{1'b1}},     8'd31},
        '{(96'd1 << 63) | (96'd1 << 94),  (96'd1 << 63) | (96'd1 << 94), 8'd63}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_lines = '0;
    logic          cpu_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lvl_irq_hub #(.NUM_LINES(NL), .LVL_W(8), .RST_CYC(4),
                  .REV_MAJOR(2), .REV_MINOR(1)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 12'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 12'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int b = 0; b < 3; b++) begin
            rd(32'h84 + 32 * b, d); check("R1 mask reset", d, 32'hFFFF_FFFF);
        end
        #1 check("R1 irq low", 32'(cpu_irq), 0);
        rd(32'h040, d); check("R1 active", d, 0);
        rd(32'h014, d); check("R1 status", d, 1);
        rd(32'h010, d); check("R1 config", d, 0);
        rd(32'h068, d); check("R1 threshold", d, 0);
        rd(32'h000, d); check("R9 revision", d, 32'h21);

        // R2 aliases and direct write on bank 2
        wr(32'hC8, 32'h0000_0003);
        rd(32'hC4, d); check("R2 clr alias", d, 32'hFFFF_FFFC);
        wr(32'hC8, 32'h0);
        rd(32'hC4, d); check("R2 clr zeros", d, 32'hFFFF_FFFC);
        wr(32'hCC, 32'h0000_0001);
        rd(32'hC4, d); check("R2 set alias", d, 32'hFFFF_FFFD);
        wr(32'hCC, 32'h0);
        rd(32'hC4, d); check("R2 set zeros", d, 32'hFFFF_FFFD);
        wr(32'hC4, 32'h1234_5678);
        rd(32'hC4, d); check("R2 direct", d, 32'h1234_5678);
        wr(32'hC4, 32'hFFFF_FFFF);

        // R3 pending on bank 1: lines 32,33 enabled, 32 and 34 raised
        wr(32'hA8, 32'h3);
        irq_lines[32] = 1'b1;
        irq_lines[34] = 1'b1;
        rd(32'hB8, d); check("R3 pending", d, 32'h1);
        rd(32'h040, d); check("R4 first latch", d, 32);

        // R5 hold while a lower line arrives and the held line drops
        wr(32'h88, 32'h4);
        irq_lines[2] = 1'b1;
        rd(32'h040, d); check("R5 held vs lower", d, 32);
        irq_lines[32] = 1'b0;
        rd(32'h040, d); check("R5 held after drop", d, 32);
        wr(32'h048, 32'h0);
        #1 check("R6 zero write ignored", 32'(cpu_irq), 1);

        // R6 acknowledge gap of one cycle then relatch
        wr(32'h048, 32'h1);
        #1 check("R6 gap low", 32'(cpu_irq), 0);
        @(negedge clk); #1 check("R6 relatch high", 32'(cpu_irq), 1);
        rd(32'h040, d); check("R6 next id", d, 2);
        irq_lines = '0;
        wr(32'h048, 32'h1);

        // R4 table of patterns
        for (int v = 0; v < 7; v++) begin
            irq_lines = '0;
            repeat (2) @(negedge clk);
            if (cpu_irq) wr(32'h048, 32'h1);
            repeat (2) @(negedge clk);
            for (int b = 0; b < 3; b++) begin
                wr(32'h8C + 32 * b, 32'hFFFF_FFFF);
                wr(32'h88 + 32 * b, VECS[v].en[b*32 +: 32]);
            end
            irq_lines = VECS[v].raw;
            repeat (3) @(negedge clk);
            #1 check("R4 table irq", 32'(cpu_irq), 1);
            rd(32'h040, d); check("R4 table id", d, 32'(VECS[v].id));
            rd(32'h98 + 32 * (VECS[v].id / 32), d);
            check("R3 table pend bit", 32'(d[VECS[v].id % 32]), 1);
        end
        irq_lines = '0;
        wr(32'h048, 32'h1);

        // R11 per-line storage
        wr(32'h100 + 4 * 7, 32'hA5);
        wr(32'h100 + 4 * 95, 32'h3C);
        wr(32'h100 + 4 * 1, 32'hFFFF);
        rd(32'h100 + 4 * 7, d);  check("R11 line7", d, 32'hA5);
        rd(32'h100 + 4 * 95, d); check("R11 line95", d, 32'h3C);
        rd(32'h100 + 4 * 1, d);  check("R11 width", d, 32'hFF);

        // R10 plain storage, R12 unmapped
        wr(32'h068, 32'hFFFF_FFFF);
        wr(32'h050, 32'hFFFF_FFFF);
        wr(32'h04C, 32'hFFFF_FFFF);
        rd(32'h068, d); check("R10 threshold", d, 32'hFF);
        rd(32'h050, d); check("R10 idle", d, 32'h3);
        rd(32'h04C, d); check("R10 protection", d, 32'h1);
        rd(32'h020, d); check("R12 unmapped", d, 0);
        rd(32'hE4, d);  check("R12 beyond banks", d, 0);

        // R8 autoidle
        wr(32'h010, 32'h1);
        rd(32'h010, d); check("R8 autoidle", d, 1);

        // R7 soft reset
        wr(32'h010, 32'h2);
        rd(32'h014, d); check("R7 status busy", d, 0);
        rd(32'h010, d); check("R7 config busy", d, 32'h2);
        repeat (6) @(negedge clk);
        rd(32'h014, d); check("R7 status done", d, 1);
        rd(32'h010, d); check("R7 bit self-clear", d, 0);
        rd(32'h084, d); check("R7 mask restored", d, 32'hFFFF_FFFF);
        rd(32'h068, d); check("R7 threshold cleared", d, 0);
        rd(32'h100 + 4 * 7, d); check("R7 line store cleared", d, 0);
        #1 check("R7 irq low", 32'(cpu_irq), 0);

        summary();
        $finish;
    end
endmodule